// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

The block divides an unsigned dividend of `2*DW` bits by an unsigned divisor of `DW` bits and returns a `DW`-bit quotient and a `DW`-bit remainder. It computes one quotient bit per clock. It never puts a partial remainder back after a subtraction that went negative. Instead, the next step adds the divisor rather than subtracting it. One correction step after the last iteration turns a negative final remainder into the true one.

A caller presents the operands with a one-cycle `start`. The block accepts `start` when it is not busy. If the upper half of the dividend is at least the divisor, the quotient cannot fit in `DW` bits, and this check also covers a zero divisor. In that case the block skips the iterations and reports the error with `done` on the next cycle.

The controller has four named states:
- `ST_IDLE` waits for a request.
- `ST_ITER` performs the `DW` shift/add-subtract steps.
- `ST_CORRECT` repairs a negative remainder.
- `ST_FINISH` pulses `done`.

It moves between them on these transitions:
- IDLE→ITER: accepted start with valid operands.
- IDLE→FINISH: accepted start with invalid operands.
- ITER→ITER: not yet the last step.
- ITER→CORRECT: last step.
- CORRECT→FINISH: always.
- FINISH→IDLE: no start.
- FINISH→ITER or FINISH→FINISH: a new start is accepted in the `done` cycle.

Top module: `seq_nr_divider`

## Requirements
- R1: For an accepted request whose dividend upper half is below the divisor, the results satisfy dividend = quotient*divisor + remainder with remainder < divisor, and `div_error` is 0.
- R2: `done` rises exactly DW+1 clock edges after the edge that accepts `start`, and stays high for one cycle only.
- R3: If the dividend upper half is greater than or equal to the divisor (including divisor 0), `div_error` is 1 and `done` is high right after the accepting edge, with `busy` low.
- R4: `busy` is high from the accepting edge until `done` rises, and `busy` and `done` are never high together.
- R5: A `start` while `busy` is high is ignored; the running division finishes with its own operands.
- R6: After reset, `busy`, `done`, `div_error`, `quotient` and `remainder` are all 0.
- R7: After `done`, `quotient`, `remainder` and `div_error` hold their values until the next accepted `start`.
- R8: When the final partial remainder is negative (quotient LSB 0), the correction step adds the divisor once, so the remainder output is still the true remainder.
- R9: The largest quotient, all ones, is produced when the dividend is divisor*2^DW - 1; the remainder is then divisor-1.
- R10: Each step subtracts the divisor when the previous partial remainder is non-negative and adds it when it is negative. The add/subtract choice and each quotient bit (MSB first) are taken from the XOR of `divisor_neg` with the new remainder's sign, where `divisor_neg` is held at 0 for unsigned use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted when not busy |
| dividend | input | 2*DW | Unsigned dividend |
| divisor | input | DW | Unsigned divisor |
| divisor_neg | input | 1 | Divisor sign bit feeding the XOR control; tie to 0 |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | DW | Quotient, held after done |
| remainder | output | DW | Remainder, held after done |
| div_error | output | 1 | Overflow or divide-by-zero for the last request |

## Verification
Random operands with the dividend upper half below a random non-zero divisor exercise the main function. A mix of positive and negative partial remainders at each step separates a correct add/subtract alternation from one that always subtracts or restores.

Directed dividends are chosen for specific outcomes:
- A zero dividend and quotients with LSB 0 leave a negative final remainder, which exposes a missing or wrong correction step.
- The all-ones quotient case shows whether the MSB-first bit ordering and the width boundary are right.
- Divisor zero, an upper half exactly equal to the divisor, and randomly mixed overflowing requests separate a `>=` overflow test from `>`.

A second `start` injected mid-run shows whether operands are captured only on acceptance.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ITER    = 2'd1,
        ST_CORRECT = 2'd2,
        ST_FINISH  = 2'd3
    } nrdiv_state_t;

endpackage

// File: rtl/nrdiv_addsub.sv
// Two's complement adder/subtractor: sum = a + b, or a - b when sub is set.
module nrdiv_addsub #(
    parameter int W = 10
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum
);
    always_comb begin
        sum = a + (b ^ {W{sub}}) + W'(sub);
    end
endmodule

// File: rtl/nrdiv_ctrl.sv
// Sequencer: idle, DW iterations, correction, completion pulse.
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bad_ops,
    output logic accept,
    output logic load,
    output logic step,
    output logic fix,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    nrdiv_state_t st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          can_take;

    // next-state logic
    always_comb begin
        can_take = (st_q == ST_IDLE) || (st_q == ST_FINISH);
        st_d     = st_q;
        unique case (st_q)
            ST_IDLE, ST_FINISH: begin
                if (start) st_d = bad_ops ? ST_FINISH : ST_ITER;
                else       st_d = ST_IDLE;
            end
            ST_ITER: begin
                if (cnt_q == LAST) st_d = ST_CORRECT;
            end
            ST_CORRECT: st_d = ST_FINISH;
            default:    st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        accept = start && can_take;
        load   = accept && !bad_ops;
        step   = (st_q == ST_ITER);
        fix    = (st_q == ST_CORRECT);
        busy   = (st_q == ST_ITER) || (st_q == ST_CORRECT);
        done   = (st_q == ST_FINISH);
    end
endmodule

// File: rtl/nrdiv_datapath.sv
// Partial remainder, dividend low bits, quotient and error flag.
module nrdiv_datapath #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            load,
    input  logic            step,
    input  logic            fix,
    input  logic            bad_ops,
    input  logic [2*DW-1:0] dividend,
    input  logic [DW-1:0]   divisor,
    input  logic            divisor_neg,
    output logic [DW-1:0]   quotient,
    output logic [DW-1:0]   remainder,
    output logic            div_error
);
    localparam int RW = DW + 2;

    logic [RW-1:0] rem_q;
    logic [DW-1:0] low_q;
    logic [DW-1:0] quo_q;
    logic [DW-1:0] dvs_q;
    logic          sub_q;
    logic          err_q;

    logic [RW-1:0] shifted;
    logic [RW-1:0] dvs_ext;
    logic [RW-1:0] step_res;
    logic [RW-1:0] fix_res;
    logic          nonneg_new;
    logic          qbit;

    assign shifted = {rem_q[DW:0], low_q[DW-1]};
    assign dvs_ext = {2'b00, dvs_q};

    nrdiv_addsub #(.W(RW)) u_step_as (
        .a   (shifted),
        .b   (dvs_ext),
        .sub (sub_q),
        .sum (step_res)
    );

    nrdiv_addsub #(.W(RW)) u_fix_as (
        .a   (rem_q),
        .b   (dvs_ext),
        .sub (1'b0),
        .sum (fix_res)
    );

    // carry-sense: complement of the new remainder sign
    assign nonneg_new = ~step_res[RW-1];
    assign qbit       = divisor_neg ^ nonneg_new;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            low_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            sub_q <= 1'b0;
        end else if (load) begin
            rem_q <= {2'b00, dividend[2*DW-1:DW]};
            low_q <= dividend[DW-1:0];
            quo_q <= '0;
            dvs_q <= divisor;
            sub_q <= 1'b1;
        end else if (step) begin
            rem_q <= step_res;
            low_q <= {low_q[DW-2:0], 1'b0};
            quo_q <= {quo_q[DW-2:0], qbit};
            sub_q <= qbit;
        end else if (fix) begin
            if (rem_q[RW-1]) rem_q <= fix_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (accept) err_q <= bad_ops;
    end

    assign quotient  = quo_q;
    assign remainder = rem_q[DW-1:0];
    assign div_error = err_q;
endmodule

// File: rtl/seq_nr_divider.sv
module seq_nr_divider #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2*DW-1:0] dividend,
    input  logic [DW-1:0]   divisor,
    input  logic            divisor_neg,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   quotient,
    output logic [DW-1:0]   remainder,
    output logic            div_error
);
    logic accept, load, step, fix, bad_ops;

    // quotient cannot fit (also catches divisor zero)
    assign bad_ops = (dividend[2*DW-1:DW] >= divisor);

    nrdiv_ctrl #(.DW(DW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .bad_ops (bad_ops),
        .accept  (accept),
        .load    (load),
        .step    (step),
        .fix     (fix),
        .busy    (busy),
        .done    (done)
    );

    nrdiv_datapath #(.DW(DW)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .load        (load),
        .step        (step),
        .fix         (fix),
        .bad_ops     (bad_ops),
        .dividend    (dividend),
        .divisor     (divisor),
        .divisor_neg (divisor_neg),
        .quotient    (quotient),
        .remainder   (remainder),
        .div_error   (div_error)
    );
endmodule

// File: rtl/nrdiv_checker.sv
module nrdiv_checker #(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [2*DW-1:0] dividend,
    input logic [DW-1:0]   divisor,
    input logic            busy,
    input logic            done,
    input logic [DW-1:0]   quotient,
    input logic [DW-1:0]   remainder,
    input logic            div_error
);
    localparam int NW = 2 * DW;
    localparam int CW = $clog2(DW + 3) + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic            acc;
    logic [NW-1:0]   dvd_lat;
    logic [DW-1:0]   dvs_lat;
    logic [CW-1:0]   cyc;
    logic            quiet_prev;
    logic [DW-1:0]   q_prev, r_prev;
    logic            e_prev;
    logic [NW-1:0]   recon;

    assign acc   = start && !busy;
    assign recon = {{DW{1'b0}}, quotient} * {{DW{1'b0}}, dvs_lat}
                 + {{DW{1'b0}}, remainder};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_lat    <= '0;
            dvs_lat    <= '0;
            cyc        <= CMAX;
            quiet_prev <= 1'b0;
            q_prev     <= '0;
            r_prev     <= '0;
            e_prev     <= 1'b0;
        end else begin
            if (acc) begin
                dvd_lat <= dividend;
                dvs_lat <= divisor;
                cyc     <= '0;
            end else if (cyc != CMAX) begin
                cyc <= cyc + 1'b1;
            end
            quiet_prev <= !busy && !acc;
            q_prev     <= quotient;
            r_prev     <= remainder;
            e_prev     <= div_error;
        end
    end

    a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
        done && !div_error |-> recon == dvd_lat);

    a_r1_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
        done && !div_error |-> remainder < dvs_lat);

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done && !div_error |-> cyc == CW'(DW + 1));

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !done);

    a_r3_flag_next: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (dividend[NW-1:DW] >= divisor) |=> done && div_error && !busy);

    a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_prev && !busy |-> quotient == q_prev && remainder == r_prev
                                && div_error == e_prev);
endmodule

bind seq_nr_divider nrdiv_checker #(.DW(DW)) u_nrdiv_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_error (div_error)
);

// File: tb/seq_nr_divider_bench.sv
module seq_nr_divider_bench;
    localparam int DW = 8;
    localparam int NW = 2 * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] dividend = '0;
    logic [DW-1:0] divisor = '0;
    logic          divisor_neg = 1'b0;
    logic          busy, done, div_error;
    logic [DW-1:0] quotient, remainder;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    seq_nr_divider #(.DW(DW)) u_seq_nr_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .divisor_neg (divisor_neg),
        .busy        (busy),
        .done        (done),
        .quotient    (quotient),
        .remainder   (remainder),
        .div_error   (div_error)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ref_quo(input logic [NW-1:0] a, input logic [DW-1:0] b);
        logic [NW-1:0] full;
        full = a / {{DW{1'b0}}, b};
        return full[DW-1:0];
    endfunction

    function automatic logic [DW-1:0] ref_rem(input logic [NW-1:0] a, input logic [DW-1:0] b);
        logic [NW-1:0] full;
        full = a % {{DW{1'b0}}, b};
        return full[DW-1:0];
    endfunction

    function automatic bit ref_bad(input logic [NW-1:0] a, input logic [DW-1:0] b);
        return a[NW-1:DW] >= b;
    endfunction

    // one request; poke injects a start with other operands mid-run (R5)
    task automatic run_div(input logic [NW-1:0] a, input logic [DW-1:0] b,
                           input bit poke, input string req);
        int  lat;
        bit  busy_ok;
        logic [DW-1:0] q_hold, r_hold;
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(posedge clk);
        #1;
        start    = 1'b0;
        dividend = ~a;
        divisor  = b + 8'd3;
        if (ref_bad(a, b)) begin
            check(done == 1'b1, "R3", "done after accept", done, 1);
            check(div_error == 1'b1, "R3", "error flag", div_error, 1);
            check(busy == 1'b0, "R3", "busy low", busy, 0);
        end else begin
            lat = 0;
            busy_ok = 1'b1;
            while (!done && lat < 40) begin
                if (!busy) busy_ok = 1'b0;
                if (poke && lat == 2) start = 1'b1;
                @(posedge clk);
                #1;
                start = 1'b0;
                lat++;
            end
            check(busy_ok, "R4", "busy during run", busy_ok, 1);
            check(busy == 1'b0, "R4", "busy with done", busy, 0);
            check(lat == DW + 1, "R2", "latency", lat, DW + 1);
            check(div_error == 1'b0, req, "error flag", div_error, 0);
            check(quotient == ref_quo(a, b), poke ? "R5" : req, "quotient",
                  quotient, ref_quo(a, b));
            check(remainder == ref_rem(a, b), poke ? "R5" : req, "remainder",
                  remainder, ref_rem(a, b));
        end
        q_hold = quotient;
        r_hold = remainder;
        @(posedge clk);
        #1;
        check(done == 1'b0, "R2", "done one cycle", done, 0);
        repeat (2) @(posedge clk);
        #1;
        if (!ref_bad(a, b)) begin
            check(quotient == q_hold, "R7", "quotient held", quotient, q_hold);
            check(remainder == r_hold, "R7", "remainder held", remainder, r_hold);
        end
        check(div_error == ref_bad(a, b), "R7", "error held", div_error, ref_bad(a, b));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [DW-1:0] b;
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R6: reset values
        check(busy == 0 && done == 0, "R6", "busy/done at reset", {busy, done}, 0);
        check(div_error == 0, "R6", "error at reset", div_error, 0);
        check(quotient == 0 && remainder == 0, "R6", "results at reset",
              {quotient, remainder}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run_div(16'd100, 8'd7, 1'b0, "R1");
        run_div(16'd9, 8'd4, 1'b0, "R8");        // quotient LSB 0, negative last step
        run_div(16'd0, 8'd5, 1'b0, "R8");        // every step negative
        run_div(16'hFEFF, 8'hFF, 1'b0, "R9");    // all-ones quotient
        run_div(16'h00FF, 8'd1, 1'b0, "R9");
        run_div(16'h12FF, 8'h13, 1'b0, "R10");   // alternating signs
        run_div(16'h1234, 8'd0, 1'b0, "R3");     // divide by zero
        run_div(16'h0500, 8'd5, 1'b0, "R3");     // upper half equal
        run_div(16'h0A00, 8'd5, 1'b0, "R3");
        run_div(16'h3456, 8'h77, 1'b1, "R5");

        for (int i = 0; i < 300; i++) begin
            b  = DW'($urandom_range(1, 255));
            hi = DW'($urandom_range(0, int'(b) - 1));
            lo = DW'($urandom);
            if ($urandom_range(0, 9) == 0) hi = DW'($urandom_range(int'(b), 255));
            run_div({hi, lo}, b, ($urandom_range(0, 15) == 0), "R10");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule